// File: doc/BRIEF.md
# Static-Policy Branch Fetch Controller

This block drives instruction fetch for a five-stage in-order pipeline and handles conditional branches. It uses one of three static policies, chosen at run time: freeze, predict-not-taken and predict-taken. None of the policies keeps any branch history. Each cycle the block presents a fetch address and a fetch enable. A kill mask marks which in-flight instruction slots must turn into bubbles in the current cycle. A bubble writes nothing and takes no part in later branch handling.

The decoder reports that the instruction in decode is a branch and supplies its target. The execute stage supplies the outcome and target of the branch that has reached it. The block tracks the validity, address and branch marking of every slot from decode up to execute, so it knows on its own when a branch resolves and which younger slots it must discard. Three event counters report branches seen, mispredictions and cycles spent with fetch stopped. A bench can use them to compare the penalty of each policy with its expected value.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: After synchronous reset, `pc` equals `RESET_PC`, `fetch_en` is 1, all three counters are 0 and `kill_mask` is 0.
- R2: With no branch activity, `pc` advances by one each cycle in which `fetch_en` is 1. Bit 0 of `kill_mask` refers to the instruction being fetched this cycle. Bit k (1 ≤ k ≤ SPAN) refers to the instruction k−1 stages past decode, so bit 1 is decode itself.
- R3: `policy_sel` encoding: 00 freeze, 01 predict-not-taken, 10 predict-taken. The value 11 behaves exactly as predict-not-taken.
- R4: Freeze policy: when a branch is detected, the slot being fetched is killed and `fetch_en` falls for SPAN cycles. The next fetch is from the resolved address: the target if taken, otherwise the branch address plus one.
- R5: Predict-not-taken: an untaken branch causes no kill and no redirect. A taken branch, in its resolve cycle, kills every valid younger slot (fetch and stages 0..SPAN−1 past decode), and the next `pc` is the target.
- R6: Predict-taken: detection kills the slot being fetched, and the next `pc` is the decode target. An untaken resolution kills every valid younger slot and sends fetch to the branch address plus one. A taken resolution kills nothing.
- R7: `dec_branch` has no effect when decode holds no valid instruction, or when that instruction is killed in the same cycle.
- R8: A new `policy_sel` value is accepted only while no detected branch remains unresolved. Until then, branches keep the policy already latched.
- R9: `branch_count` counts detected branches. `mispredict_count` counts predicted branches that resolve against their prediction. `stall_count` counts cycles with `fetch_en` at 0.
- R10: `ex_taken` and `ex_target` are ignored in any cycle where execute holds no valid detected branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 2 | Requested branch policy |
| dec_branch | input | 1 | Instruction in decode is a branch |
| dec_target | input | AW | Target computed in decode |
| ex_taken | input | 1 | Outcome of the branch in execute |
| ex_target | input | AW | Target of the branch in execute |
| pc | output | AW | Fetch address this cycle |
| fetch_en | output | 1 | Fetch active this cycle |
| kill_mask | output | SPAN+1 | Slots turned into bubbles this cycle |
| branch_count | output | CW | Detected branches |
| mispredict_count | output | CW | Wrong predictions |
| stall_count | output | CW | Cycles with fetch stopped |

## Verification
The bench builds the block with SPAN=3, one stage more than the default. This widens the kill mask to four bits and lengthens the freeze stall to three cycles, so an off-by-one in the stage tracking or in the stall window changes the observed mask and counts. AW=16 leaves room for forward jumps of 37 and a fixed target of 100 without wrap. Random policy changes while branches are in flight exercise the latching rule. Noise on the decode and execute inputs while the matching slot is empty or killed exercises the rules that such inputs are ignored.

// File: rtl/bhf_pkg.sv
package bhf_pkg;
  typedef enum logic [1:0] {
    POL_FREEZE   = 2'b00,
    POL_NOTTAKEN = 2'b01,
    POL_TAKEN    = 2'b10,
    POL_SPARE    = 2'b11
  } pol_e;
endpackage

// File: rtl/bhf_event_ctr.sv
module bhf_event_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] STEP = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + STEP;
  end
endmodule

// File: rtl/bhf_stage_track.sv
// Tracks validity, address and branch marking of each slot from decode
// (stage 0) to execute (stage SPAN).
module bhf_stage_track #(
  parameter int AW   = 16,
  parameter int SPAN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] in_adr,
  input  logic          mark_br,
  input  logic          mark_ptk,
  input  logic          mark_frz,
  input  logic          flush,
  output logic          di_vld,
  output logic          ex_vld,
  output logic          ex_br,
  output logic          ex_ptk,
  output logic          ex_frz,
  output logic [AW-1:0] ex_adr,
  output logic [SPAN-1:0] occ,
  output logic          unres
);
  logic [SPAN:0]  vld;
  logic [SPAN:1]  br, ptk, frz;
  logic [AW-1:0]  adr [0:SPAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      br  <= '0;
      ptk <= '0;
      frz <= '0;
      for (int i = 0; i <= SPAN; i++) adr[i] <= '0;
    end else begin
      vld[0] <= in_vld;
      adr[0] <= in_adr;
      // entry into the first stage past decode picks up the branch marking
      vld[1] <= vld[0] & ~flush;
      br[1]  <= mark_br;
      ptk[1] <= mark_ptk;
      frz[1] <= mark_frz;
      adr[1] <= adr[0];
      for (int i = 2; i <= SPAN; i++) begin
        vld[i] <= vld[i-1] & ~flush;
        br[i]  <= br[i-1];
        ptk[i] <= ptk[i-1];
        frz[i] <= frz[i-1];
        adr[i] <= adr[i-1];
      end
    end
  end

  assign di_vld = vld[0];
  assign ex_vld = vld[SPAN];
  assign ex_br  = br[SPAN];
  assign ex_ptk = ptk[SPAN];
  assign ex_frz = frz[SPAN];
  assign ex_adr = adr[SPAN];
  assign occ    = vld[SPAN-1:0];
  assign unres  = |(vld[SPAN:1] & br[SPAN:1]);
endmodule

// File: rtl/bhf_steer.sv
// Decides detection, resolution, kill mask and next fetch state.
module bhf_steer
  import bhf_pkg::*;
#(
  parameter int AW   = 16,
  parameter int SPAN = 2
) (
  input  pol_e            pol,
  input  logic            fe,
  input  logic [AW-1:0]   pc,
  input  logic            di_vld,
  input  logic            dec_branch,
  input  logic [AW-1:0]   dec_target,
  input  logic            ex_vld,
  input  logic            ex_br,
  input  logic            ex_ptk,
  input  logic            ex_frz,
  input  logic [AW-1:0]   ex_adr,
  input  logic            ex_taken,
  input  logic [AW-1:0]   ex_target,
  input  logic [SPAN-1:0] occ,
  output logic            detect,
  output logic            det_ptk,
  output logic            det_frz,
  output logic            mis,
  output logic            restart,
  output logic [AW-1:0]   fix_adr,
  output logic [AW-1:0]   nxt_pc,
  output logic            nxt_fe,
  output logic [SPAN:0]   kill
);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic resolving;

  always_comb begin
    det_ptk   = (pol == POL_TAKEN);
    det_frz   = (pol == POL_FREEZE);
    resolving = ex_vld & ex_br;
    mis       = resolving & ~ex_frz & (ex_taken ^ ex_ptk);
    restart   = resolving & ex_frz;
    fix_adr   = ex_taken ? ex_target : (ex_adr + ADR_ONE);
    detect    = di_vld & dec_branch & ~mis;

    kill    = '0;
    kill[0] = fe & (mis | (detect & (det_ptk | det_frz)));
    for (int k = 1; k <= SPAN; k++) kill[k] = mis & occ[k-1];

    if (mis || restart) begin
      nxt_pc = fix_adr;
      nxt_fe = 1'b1;
    end else if (detect && det_frz) begin
      nxt_pc = pc;
      nxt_fe = 1'b0;
    end else if (detect && det_ptk) begin
      nxt_pc = dec_target;
      nxt_fe = 1'b1;
    end else begin
      nxt_pc = fe ? (pc + ADR_ONE) : pc;
      nxt_fe = fe;
    end
  end
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
  import bhf_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          SPAN     = 2,
  parameter int          CW       = 16,
  parameter int unsigned RESET_PC = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      policy_sel,
  input  logic            dec_branch,
  input  logic [AW-1:0]   dec_target,
  input  logic            ex_taken,
  input  logic [AW-1:0]   ex_target,
  output logic [AW-1:0]   pc,
  output logic            fetch_en,
  output logic [SPAN:0]   kill_mask,
  output logic [CW-1:0]   branch_count,
  output logic [CW-1:0]   mispredict_count,
  output logic [CW-1:0]   stall_count
);
  localparam int NUM_EV = 3;
  localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);

  logic [AW-1:0]   pc_q, nxt_pc, fix_adr, ex_adr;
  logic            fe_q, nxt_fe;
  pol_e            pol_q, pol_eff;
  logic            di_vld, ex_vld, ex_br, ex_ptk, ex_frz, unres;
  logic [SPAN-1:0] occ;
  logic            detect, det_ptk, det_frz, mis, restart;
  logic [SPAN:0]   kill;
  logic [NUM_EV-1:0] ev;
  logic [CW-1:0]   cnt [NUM_EV];

  // policy is only re-sampled while nothing is waiting to resolve
  assign pol_eff = unres ? pol_q : pol_e'(policy_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= PC_INIT;
      fe_q  <= 1'b1;
      pol_q <= POL_NOTTAKEN;
    end else begin
      pc_q  <= nxt_pc;
      fe_q  <= nxt_fe;
      pol_q <= pol_eff;
    end
  end

  bhf_stage_track #(.AW(AW), .SPAN(SPAN)) u_track (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (fe_q & ~kill[0]),
    .in_adr   (pc_q),
    .mark_br  (detect),
    .mark_ptk (det_ptk),
    .mark_frz (det_frz),
    .flush    (mis),
    .di_vld   (di_vld),
    .ex_vld   (ex_vld),
    .ex_br    (ex_br),
    .ex_ptk   (ex_ptk),
    .ex_frz   (ex_frz),
    .ex_adr   (ex_adr),
    .occ      (occ),
    .unres    (unres)
  );

  bhf_steer #(.AW(AW), .SPAN(SPAN)) u_steer (
    .pol        (pol_eff),
    .fe         (fe_q),
    .pc         (pc_q),
    .di_vld     (di_vld),
    .dec_branch (dec_branch),
    .dec_target (dec_target),
    .ex_vld     (ex_vld),
    .ex_br      (ex_br),
    .ex_ptk     (ex_ptk),
    .ex_frz     (ex_frz),
    .ex_adr     (ex_adr),
    .ex_taken   (ex_taken),
    .ex_target  (ex_target),
    .occ        (occ),
    .detect     (detect),
    .det_ptk    (det_ptk),
    .det_frz    (det_frz),
    .mis        (mis),
    .restart    (restart),
    .fix_adr    (fix_adr),
    .nxt_pc     (nxt_pc),
    .nxt_fe     (nxt_fe),
    .kill       (kill)
  );

  assign ev = {~fe_q, mis, detect};

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ctr
    bhf_event_ctr #(.CW(CW)) u_ctr (
      .clk (clk),
      .rst (rst),
      .inc (ev[g]),
      .cnt (cnt[g])
    );
  end

  assign pc               = pc_q;
  assign fetch_en         = fe_q;
  assign kill_mask        = kill;
  assign branch_count     = cnt[0];
  assign mispredict_count = cnt[1];
  assign stall_count      = cnt[2];
endmodule

// File: rtl/branch_fetch_ctrl_chk.sv
module branch_fetch_ctrl_chk #(
  parameter int          AW       = 16,
  parameter int          SPAN     = 2,
  parameter int          CW       = 16,
  parameter int unsigned RESET_PC = 0
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pc,
  input logic          fetch_en,
  input logic [SPAN:0] kill_mask,
  input logic [CW-1:0] stall_count,
  input logic [CW-1:0] branch_count,
  input logic          detect,
  input logic          det_frz,
  input logic          det_ptk,
  input logic          mis,
  input logic          restart,
  input logic [AW-1:0] fix_adr,
  input logic [AW-1:0] dec_target
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_en && pc == AW'(RESET_PC) && stall_count == '0 && branch_count == '0));

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && !mis && !restart && !(detect && (det_frz || det_ptk)))
      |=> pc == $past(pc) + AW'(1));

  p_freeze_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (detect && det_frz) |=> !fetch_en);

  p_freeze_resume_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (fetch_en && pc == $past(fix_adr)));

  p_mis_redirect_r5: assert property (@(posedge clk) disable iff (rst)
    mis |=> (fetch_en && pc == $past(fix_adr)));

  p_kill_fetch_live_r5: assert property (@(posedge clk) disable iff (rst)
    kill_mask[0] |-> fetch_en);

  p_taken_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (detect && det_ptk) |=> pc == $past(dec_target));

  p_stall_count_r9: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> stall_count == $past(stall_count) + CW'(1));

  p_branch_count_r9: assert property (@(posedge clk) disable iff (rst)
    detect |=> branch_count == $past(branch_count) + CW'(1));
endmodule

bind branch_fetch_ctrl branch_fetch_ctrl_chk #(
  .AW(AW), .SPAN(SPAN), .CW(CW), .RESET_PC(RESET_PC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pc           (pc),
  .fetch_en     (fetch_en),
  .kill_mask    (kill_mask),
  .stall_count  (stall_count),
  .branch_count (branch_count),
  .detect       (detect),
  .det_frz      (det_frz),
  .det_ptk      (det_ptk),
  .mis          (mis),
  .restart      (restart),
  .fix_adr      (fix_adr),
  .dec_target   (dec_target)
);

// File: tb/branch_fetch_ctrl_test.sv
`timescale 1ns/1ps
module branch_fetch_ctrl_test;
  localparam int AW   = 16;
  localparam int SPAN = 3;
  localparam int CW   = 16;
  localparam int MASK = (1 << AW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      policy_sel = 2'b01;
  logic            dec_branch = 1'b0;
  logic [AW-1:0]   dec_target = '0;
  logic            ex_taken = 1'b0;
  logic [AW-1:0]   ex_target = '0;
  logic [AW-1:0]   pc;
  logic            fetch_en;
  logic [SPAN:0]   kill_mask;
  logic [CW-1:0]   branch_count, mispredict_count, stall_count;

  always #2.5 clk = ~clk;

  branch_fetch_ctrl #(.AW(AW), .SPAN(SPAN), .CW(CW), .RESET_PC(0)) uut (
    .clk(clk), .rst(rst), .policy_sel(policy_sel),
    .dec_branch(dec_branch), .dec_target(dec_target),
    .ex_taken(ex_taken), .ex_target(ex_target),
    .pc(pc), .fetch_en(fetch_en), .kill_mask(kill_mask),
    .branch_count(branch_count), .mispredict_count(mispredict_count),
    .stall_count(stall_count)
  );

  // behavioural model: a queue of in-flight instructions tagged by age
  typedef struct { int adr; bit br; bit ptk; bit frz; int age; } rec_t;
  rec_t q[$];
  int   m_pc, m_pol, e_br, e_mis, e_stall;
  bit   m_fe;
  int   n_chk = 0, n_fail = 0;
  int   mode = 0;
  bit   single_tk = 0;
  bit   done = 0;
  string tag = "R1";

  function automatic bit is_br(int a);
    if (mode == 1) return (a % 8) == 5;
    if (mode == 2) return a == 4;
    return 0;
  endfunction
  function automatic bit br_tk(int a);
    if (mode == 2) return single_tk;
    return ((a >> 3) & 1) == 1;
  endfunction
  function automatic int br_tgt(int a);
    if (mode == 2) return 100;
    return (a + 37) & MASK;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dec_branch = 0; ex_taken = 0; policy_sel = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete(); m_pc = 0; m_fe = 1; m_pol = 1; e_br = 0; e_mis = 0; e_stall = 0;
  endtask

  // one cycle: drive at negedge, compare, then advance the model
  task automatic step(int sel, bit noise);
    int di = -1, ex = -1, pol, fix = 0;
    bit unres = 0, mis = 0, rs = 0, detect, tk = 0;
    logic [SPAN:0] ek;
    rec_t nq[$];
    foreach (q[i]) begin
      if (q[i].age == 0) di = i;
      if (q[i].age == SPAN) ex = i;
      if (q[i].br && q[i].age >= 1) unres = 1;
    end
    policy_sel = sel[1:0];
    if (di >= 0) begin
      dec_branch = is_br(q[di].adr);
      dec_target = AW'(br_tgt(q[di].adr));
    end else begin
      dec_branch = noise;
      dec_target = AW'($urandom);
    end
    if (ex >= 0 && q[ex].br) begin
      tk = br_tk(q[ex].adr);
      ex_taken = tk;
      ex_target = AW'(br_tgt(q[ex].adr));
    end else begin
      ex_taken = noise;
      ex_target = AW'($urandom);
    end
    #1;
    pol = unres ? m_pol : sel;
    if (ex >= 0 && q[ex].br) begin
      fix = tk ? br_tgt(q[ex].adr) : ((q[ex].adr + 1) & MASK);
      if (q[ex].frz) rs = 1;
      else if (tk != q[ex].ptk) mis = 1;
    end
    detect = (di >= 0) && dec_branch && !mis;
    ek = '0;
    if (mis) begin
      ek[0] = m_fe;
      foreach (q[i]) if (q[i].age < SPAN) ek[q[i].age + 1] = 1'b1;
    end else if (detect && (pol == 0 || pol == 2)) ek[0] = m_fe;

    chk(pc == AW'(m_pc), tag, "pc", int'(pc), m_pc);
    chk(fetch_en == m_fe, tag, "fetch_en", int'(fetch_en), int'(m_fe));
    chk(kill_mask == ek, tag, "kill_mask", int'(kill_mask), int'(ek));
    chk(branch_count == CW'(e_br), tag, "branch_count", int'(branch_count), e_br);
    chk(mispredict_count == CW'(e_mis), tag, "mispredict_count", int'(mispredict_count), e_mis);
    chk(stall_count == CW'(e_stall), tag, "stall_count", int'(stall_count), e_stall);

    if (detect) begin
      q[di].br = 1; q[di].ptk = (pol == 2); q[di].frz = (pol == 0);
    end
    e_br += int'(detect); e_mis += int'(mis); e_stall += int'(!m_fe);
    foreach (q[i]) begin
      rec_t r = q[i];
      if (mis && r.age < SPAN) continue;
      r.age++;
      if (r.age <= SPAN) nq.push_back(r);
    end
    if (m_fe && !ek[0]) nq.push_back('{m_pc, 0, 0, 0, 0});
    q = nq;
    if (mis || rs) begin m_pc = fix; m_fe = 1; end
    else if (detect && pol == 0) m_fe = 0;
    else if (detect && pol == 2) m_pc = br_tgt(q[q.size() > 0 ? 0 : 0].adr) * 0 + int'(dec_target);
    else if (m_fe) m_pc = (m_pc + 1) & MASK;
    m_pol = pol;
    @(negedge clk);
  endtask

  task automatic single(int pol, bit tk, string req);
    do_reset();
    mode = 2; single_tk = tk; tag = req;
    repeat (30) step(pol, 0);
    chk(branch_count == 1, req, "single branch_count", int'(branch_count), 1);
    chk(mispredict_count == CW'((pol == 1 && tk) || (pol == 2 && !tk)), req,
        "single mispredict_count", int'(mispredict_count), int'((pol == 1 && tk) || (pol == 2 && !tk)));
    chk(stall_count == CW'(pol == 0 ? SPAN : 0), "R9", "single stall_count",
        int'(stall_count), pol == 0 ? SPAN : 0);
  endtask

  initial begin
    do_reset();
    tag = "R1";
    chk(pc == 0, "R1", "reset pc", int'(pc), 0);
    chk(fetch_en == 1, "R1", "reset fetch_en", int'(fetch_en), 1);
    chk(kill_mask == 0, "R1", "reset kill_mask", int'(kill_mask), 0);
    chk(stall_count == 0 && branch_count == 0 && mispredict_count == 0, "R1",
        "reset counters", int'(stall_count + branch_count + mispredict_count), 0);

    mode = 0; tag = "R2";
    repeat (30) step(1, 0);

    mode = 1;
    tag = "R4"; repeat (60) step(0, 0);
    tag = "R5"; repeat (60) step(1, 0);
    tag = "R6"; repeat (60) step(2, 0);
    tag = "R3"; repeat (60) step(3, 0);
    tag = "R7"; repeat (50) step(1, 1);
    tag = "R10"; repeat (50) step(2, 1);
    tag = "R8"; repeat (120) step(int'($urandom % 4), 0);

    single(0, 1, "R4");
    single(0, 0, "R4");
    single(1, 0, "R5");
    single(1, 1, "R5");
    single(2, 1, "R6");
    single(2, 0, "R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule